// File: doc/BRIEF.md
# Context-Banked Carry and Zero Flags

This block keeps three separate carry/zero flag pairs for a small processor core: one for the main program, one for maskable interrupt service and one for non-maskable interrupt service. It tracks which of the three contexts is running. It always presents the pair that belongs to that context, so the ALU sees the right pair without any extra work.

Entering an interrupt or a non-maskable interrupt switches to the matching pair. A return-from-interrupt switches back to the context that was running before. A shallow LIFO of saved contexts makes nested entries unwind in the right order.

A pair is never cleared by a context switch. It keeps its value until it is written again while its own context is active. After reset the non-maskable context is active, so the core runs on that pair until its first return.

Top module: `ctx_flag_bank`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `mode` reads 2 (non-maskable context), all six flags are 0 and no context is saved.
- R2: The context code on `mode` is 0 for normal, 1 for interrupt and 2 for non-maskable interrupt. An `irq_enter` pulse without `nmi_enter` makes `mode` read 1 from the next cycle.
- R3: An `nmi_enter` pulse makes `mode` read 2 from the next cycle. It wins over an `irq_enter` in the same cycle, and that `irq_enter` is dropped.
- R4: A `ret_int` pulse restores the most recently saved context, in last-in first-out order.
- R5: A `ret_int` pulse while no context is saved selects the normal context (0).
- R6: Up to STACK_DEPTH (default 2) contexts are saved. An entry while the store is full discards the oldest saved context, so a later return that runs out of saved entries falls back to normal.
- R7: A `flag_we` pulse loads `c_in` and `z_in` into the pair of the active context only. The new values appear on `c_out`/`z_out` from the next cycle if the context is unchanged.
- R8: A pair that is not written keeps its values across any number of context switches.
- R9: When `flag_we` arrives in the same cycle as an entry or a return, the write goes to the context that was active before the switch.
- R10: When an entry and `ret_int` arrive in the same cycle, the entry is taken and the return is ignored: no saved context is consumed.
- R11: `c_out` and `z_out` always show the pair of the context shown on `mode`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_enter | input | 1 | One-cycle pulse: maskable interrupt entry |
| nmi_enter | input | 1 | One-cycle pulse: non-maskable interrupt entry |
| ret_int | input | 1 | One-cycle pulse: return from interrupt |
| flag_we | input | 1 | Write strobe for the active pair |
| c_in | input | 1 | New carry value |
| z_in | input | 1 | New zero value |
| c_out | output | 1 | Carry of the active context |
| z_out | output | 1 | Zero of the active context |
| mode | output | 2 | Active context code (0 normal, 1 interrupt, 2 NMI) |

## Verification
A wrong saved context does not show at the ports when it is stored. It shows only when a return pops it: `mode` then reads the wrong code one cycle after `ret_int`, and `c_out`/`z_out` switch to the wrong pair in the same cycle. A write that lands in the wrong pair stays hidden until that pair's context becomes active again, which may be many cycles later. For that reason the bench keeps a full model of all three pairs and compares `mode`, `c_out` and `z_out` after every cycle, using long random runs with nested entries and returns. A lost or extra saved entry appears only at the end of a nested unwind, so the directed cases fill the store past its depth and then drain it.

// File: rtl/ctxf_pkg.sv
package ctxf_pkg;

  typedef enum logic [1:0] {
    CTX_NORM = 2'd0,
    CTX_IRQ  = 2'd1,
    CTX_NMI  = 2'd2
  } ctx_e;

  localparam int NUM_CTX = 3;

  // Context chosen by an entry request; NMI wins over IRQ.
  function automatic ctx_e entry_target(input logic nmi, input logic irq);
    ctx_e t;
    t = CTX_NORM;
    if (nmi)      t = CTX_NMI;
    else if (irq) t = CTX_IRQ;
    return t;
  endfunction

  // Context restored by a return, given the top saved entry.
  function automatic ctx_e return_target(input logic empty, input ctx_e top);
    return empty ? CTX_NORM : top;
  endfunction

endpackage

// File: rtl/ctxf_mode_stack.sv
module ctxf_mode_stack
  import ctxf_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_enter,
  input  logic nmi_enter,
  input  logic ret_int,
  output ctx_e cur_mode
);

  localparam int CW = $clog2(DEPTH + 1);

  ctx_e          cur_q;
  ctx_e          stk_q [DEPTH];
  logic [CW-1:0] cnt_q;

  // named internal events
  logic entry_req;
  logic ret_req;
  logic stk_empty;
  logic stk_full;

  assign entry_req = irq_enter | nmi_enter;
  assign ret_req   = ret_int & ~entry_req;
  assign stk_empty = (cnt_q == '0);
  assign stk_full  = (cnt_q == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= CTX_NMI;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) stk_q[i] <= CTX_NORM;
    end else if (entry_req) begin
      cur_q    <= entry_target(nmi_enter, irq_enter);
      stk_q[0] <= cur_q;
      for (int i = 1; i < DEPTH; i++) stk_q[i] <= stk_q[i-1];
      if (!stk_full) cnt_q <= cnt_q + CW'(1);
    end else if (ret_req) begin
      cur_q <= return_target(stk_empty, stk_q[0]);
      for (int i = 0; i < DEPTH - 1; i++) stk_q[i] <= stk_q[i+1];
      stk_q[DEPTH-1] <= CTX_NORM;
      if (!stk_empty) cnt_q <= cnt_q - CW'(1);
    end
  end

  assign cur_mode = cur_q;

  // R2
  irq_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_enter && !nmi_enter) |=> (cur_q == CTX_IRQ));

  // R3
  nmi_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_enter |=> (cur_q == CTX_NMI));

  // R4
  ret_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !stk_empty) |=> (cur_q == $past(stk_q[0])));

  // R5
  ret_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && stk_empty) |=> (cur_q == CTX_NORM));

  // R10
  entry_keeps_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_req |=> (cnt_q >= $past(cnt_q)));

  // R2
  mode_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_q != ctx_e'(2'd3));

endmodule

// File: rtl/ctxf_flag_bank.sv
module ctxf_flag_bank
  import ctxf_pkg::*;
#(
  parameter int PAIRS = NUM_CTX
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  ctx_e             sel,
  input  logic             c_in,
  input  logic             z_in,
  output logic [PAIRS-1:0] c_all,
  output logic [PAIRS-1:0] z_all
);

  for (genvar g = 0; g < PAIRS; g++) begin : g_pair
    logic c_q, z_q;
    logic hit;

    assign hit = we && (int'(sel) == g);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        c_q <= 1'b0;
        z_q <= 1'b0;
      end else if (hit) begin
        c_q <= c_in;
        z_q <= z_in;
      end
    end

    assign c_all[g] = c_q;
    assign z_all[g] = z_q;

    // R7
    pair_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && int'(sel) == g) |=> (c_all[g] == $past(c_in) && z_all[g] == $past(z_in)));

    // R8
    pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && int'(sel) == g) |=> ($stable(c_all[g]) && $stable(z_all[g])));
  end

endmodule

// File: rtl/ctxf_flag_mux.sv
module ctxf_flag_mux
  import ctxf_pkg::*;
#(
  parameter int PAIRS = NUM_CTX
) (
  input  ctx_e             sel,
  input  logic [PAIRS-1:0] c_all,
  input  logic [PAIRS-1:0] z_all,
  output logic             c_sel,
  output logic             z_sel
);

  always_comb begin
    c_sel = 1'b0;
    z_sel = 1'b0;
    for (int i = 0; i < PAIRS; i++) begin
      if (int'(sel) == i) begin
        c_sel = c_all[i];
        z_sel = z_all[i];
      end
    end
  end

endmodule

// File: rtl/ctx_flag_bank.sv
module ctx_flag_bank
  import ctxf_pkg::*;
#(
  parameter int STACK_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       irq_enter,
  input  logic       nmi_enter,
  input  logic       ret_int,
  input  logic       flag_we,
  input  logic       c_in,
  input  logic       z_in,
  output logic       c_out,
  output logic       z_out,
  output logic [1:0] mode
);

  ctx_e               cur_ctx;
  logic [NUM_CTX-1:0] c_bank;
  logic [NUM_CTX-1:0] z_bank;

  ctxf_mode_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_enter (irq_enter),
    .nmi_enter (nmi_enter),
    .ret_int   (ret_int),
    .cur_mode  (cur_ctx)
  );

  // the write uses the context registered before this edge (R9)
  ctxf_flag_bank #(.PAIRS(NUM_CTX)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (flag_we),
    .sel   (cur_ctx),
    .c_in  (c_in),
    .z_in  (z_in),
    .c_all (c_bank),
    .z_all (z_bank)
  );

  ctxf_flag_mux #(.PAIRS(NUM_CTX)) u_mux (
    .sel   (cur_ctx),
    .c_all (c_bank),
    .z_all (z_bank),
    .c_sel (c_out),
    .z_sel (z_out)
  );

  assign mode = cur_ctx;

  // R9
  switch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && (irq_enter || nmi_enter || ret_int))
      |=> (c_bank[$past(cur_ctx)] == $past(c_in)));

  // R11
  active_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_out == c_bank[mode]) && (z_out == z_bank[mode]));

endmodule

// File: tb/test_ctx_flag_bank.sv
module test_ctx_flag_bank;

  logic clk = 1'b0;
  logic rst_n;
  logic irq_enter, nmi_enter, ret_int, flag_we, c_in, z_in;
  logic c_out, z_out;
  logic [1:0] mode;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  // bench model
  int m_mode;
  int m_stk [2];
  int m_cnt;
  bit m_c [3];
  bit m_z [3];

  always #10 clk = ~clk;

  ctx_flag_bank i_ctx_flag_bank (
    .clk(clk), .rst_n(rst_n), .irq_enter(irq_enter), .nmi_enter(nmi_enter),
    .ret_int(ret_int), .flag_we(flag_we), .c_in(c_in), .z_in(z_in),
    .c_out(c_out), .z_out(z_out), .mode(mode)
  );

  function automatic int model_entry_mode(bit nmi, bit irq, int cur);
    if (nmi) return 2;
    if (irq) return 1;
    return cur;
  endfunction

  task automatic model_reset();
    m_mode = 2; m_cnt = 0; m_stk[0] = 0; m_stk[1] = 0;
    for (int i = 0; i < 3; i++) begin m_c[i] = 0; m_z[i] = 0; end
  endtask

  task automatic model_step(bit irq, bit nmi, bit ret, bit we, bit c, bit z);
    if (we) begin m_c[m_mode] = c; m_z[m_mode] = z; end
    if (irq || nmi) begin
      m_stk[1] = m_stk[0];
      m_stk[0] = m_mode;
      if (m_cnt < 2) m_cnt++;
      m_mode = model_entry_mode(nmi, irq, m_mode);
    end else if (ret) begin
      if (m_cnt == 0) m_mode = 0;
      else begin
        m_mode = m_stk[0];
        m_stk[0] = m_stk[1];
        m_stk[1] = 0;
        m_cnt--;
      end
    end
  endtask

  task automatic check(string tag);
    checks++;
    if (int'(mode) != m_mode || c_out != m_c[m_mode] || z_out != m_z[m_mode]) begin
      errors++;
      $display("FAIL %s: mode/c/z actual %0d/%0b/%0b expected %0d/%0b/%0b",
               tag, mode, c_out, z_out, m_mode, m_c[m_mode], m_z[m_mode]);
    end
  endtask

  task automatic step(bit irq, bit nmi, bit ret, bit we, bit c, bit z, string tag);
    @(negedge clk);
    irq_enter = irq; nmi_enter = nmi; ret_int = ret; flag_we = we; c_in = c; z_in = z;
    @(posedge clk);
    #1;
    model_step(irq, nmi, ret, we, c, z);
    check(tag);
    @(negedge clk);
    irq_enter = 0; nmi_enter = 0; ret_int = 0; flag_we = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    rst_n = 0; irq_enter = 0; nmi_enter = 0; ret_int = 0; flag_we = 0; c_in = 0; z_in = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #1 check("R1 in reset");
    @(negedge clk) rst_n = 1;
    #1 check("R1 after release");

    // R7: write NMI pair
    step(0,0,0,1,1,0,"R7 write nmi pair");
    // R5: return with nothing saved -> normal, pair still zero (R8)
    step(0,0,1,0,0,0,"R5 empty return");
    step(0,0,0,1,0,1,"R7 write normal pair");
    // R2 entry to irq, R9 write in same cycle goes to normal
    step(1,0,0,1,1,1,"R9 write with irq entry");
    step(0,0,0,1,1,0,"R7 write irq pair");
    // R3 nmi nests over irq; NMI pair retained (R8)
    step(0,1,0,0,0,0,"R8 nmi pair retained");
    // R4 unwind
    step(0,0,1,0,0,0,"R4 return to irq");
    step(0,0,1,0,0,0,"R4 return to normal");
    step(0,0,1,0,0,0,"R5 empty return again");
    // R3 priority
    step(1,1,0,0,0,0,"R3 nmi wins over irq");
    step(0,0,1,0,0,0,"R4 back to normal");
    // R6 overflow: irq, irq, nmi then three returns
    step(1,0,0,0,0,0,"R6 fill 1");
    step(1,0,0,1,0,0,"R6 fill 2");
    step(0,1,0,0,0,0,"R6 overflow");
    step(0,0,1,0,0,0,"R6 unwind 1");
    step(0,0,1,0,0,0,"R6 unwind 2");
    step(0,0,1,0,0,0,"R6 oldest lost -> normal");
    // R10 entry and return together
    step(1,0,1,0,0,0,"R10 entry beats return");
    step(0,0,1,1,1,1,"R9 write with return");
    step(0,0,1,0,0,0,"R10 no extra pop");

    // random phase, R11 checked every cycle
    for (int n = 0; n < 4000; n++) begin
      bit r_irq, r_nmi, r_ret, r_we;
      r_irq = ($urandom % 100) < 15;
      r_nmi = ($urandom % 100) < 5;
      r_ret = ($urandom % 100) < 22;
      r_we  = ($urandom % 100) < 50;
      step(r_irq, r_nmi, r_ret, r_we, 1'($urandom), 1'($urandom), "R11 random");
    end

    finish_run();
  end

endmodule